// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler with Unit Round-Robin

This block sits between in-order dispatch and a set of functional units. Each dispatched instruction carries source tags with ready bits, the resource group it needs, a latency and a destination tag. It occupies one of `DEPTH` slots for its whole life. A slot is in one of three states: waiting for operands, ready, or executing. A result-tag broadcast marks matching sources as available. Once all sources are available the instruction moves to the ready state.

Each cycle at most one instruction issues. The choice is the oldest ready instruction whose group has a free unit. Inside that group, a per-group round-robin pointer picks the unit, so work spreads evenly. The unit stays occupied for the instruction's latency. In the last cycle of that latency the block raises a per-unit done flag carrying the destination tag, and the slot is released.

Dispatch is a valid/ready stream. `disp_ready` depends only on slot occupancy, never on inputs of the same cycle. A beat transfers when `disp_valid` and `disp_ready` are both high. While `disp_ready` is low, presented beats are dropped, and the producer must hold them. The wake broadcast, issue and done pins are plain strobes with no back-pressure.

Top module: `sched_issue_queue`

## Requirements
- R1: After reset every slot is empty: `disp_ready`=1, `iss_valid`=0 and `done_vec`=0.
- R2: An accepted instruction whose sources are all flagged ready (or woken in the same cycle) can issue no earlier than the cycle after the accepting edge. It is never visible on the issue pins in its own dispatch cycle.
- R3: A source is woken when `wake_valid` is high and `wake_tag` equals its tag. An instruction whose last source is woken in cycle t can appear on `iss_valid` in cycle t+1. It stays off the issue pins before that.
- R4: Among instructions that are ready and whose group has a free unit, the one accepted earliest is issued.
- R5: The unit is chosen inside the group by a round-robin pointer. The pointer points at the unit after the last one issued in that group, and the first free unit at or after it is taken. `iss_unit` = group × `UPG` + local unit index, and every pointer starts at 0.
- R6: A unit issued an instruction of latency L (0 counts as 1) cannot take another for L cycles. A ready instruction whose group has no free unit does not block a younger one of another group.
- R7: An instruction on `iss_valid` in cycle c raises `done_vec[unit]` with its destination tag on `done_dest` in cycle c+L, for exactly one cycle. Its slot is free from the next cycle.
- R8: `disp_ready` is low exactly when all `DEPTH` slots hold instructions, whether waiting, ready or executing. A beat offered while it is low is dropped and never issues.
- R9: At most one instruction issues per cycle, and each unit runs at most one instruction at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch beat present |
| disp_ready | output | 1 | A free slot exists |
| disp_src_tag | input | NSRC*TAG_W | Source tags, source k in bits [k*TAG_W +: TAG_W] |
| disp_src_rdy | input | NSRC | Source k already available |
| disp_grp | input | GRP_W | Resource group (must be below NGRP) |
| disp_lat | input | LAT_W | Latency / unit occupancy in cycles |
| disp_dest | input | TAG_W | Destination tag |
| wake_valid | input | 1 | Result tag broadcast strobe |
| wake_tag | input | TAG_W | Broadcast tag |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_dest | output | TAG_W | Destination tag of the issued instruction |
| iss_unit | output | UNIT_W | Global index of the chosen unit |
| done_vec | output | NUNIT | Per-unit completion strobe |
| done_dest | output | NUNIT*TAG_W | Destination tag per completing unit |

## Verification
The hardest state to reach is a full queue that mixes long-latency executing slots with waiting slots. In that state a wake arrives together with a dispatch, while both units of a group are busy and a younger instruction of the other group is ready. The bench first fills all slots with instructions blocked on one tag and offers an extra beat that must be dropped. It then releases them together, so the age order and the unit rotation are visible directly. After that, long random traffic runs with a narrow tag space and frequent wakes, so coincident wake/dispatch and full-queue cycles recur. A behavioural model predicts every output on every cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READY = 2'd2,
    ST_EXEC  = 2'd3
  } ent_state_t;

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sched_entry.sv
module sched_entry
  import sched_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int NSRC   = 2,
  parameter int GRP_W  = 1,
  parameter int LAT_W  = 3,
  parameter int UNIT_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_i,
  input  logic [NSRC*TAG_W-1:0]  src_tag_i,
  input  logic [NSRC-1:0]        src_rdy_i,
  input  logic [GRP_W-1:0]       grp_i,
  input  logic [LAT_W-1:0]       lat_i,
  input  logic [TAG_W-1:0]       dest_i,
  input  logic                   wake_v_i,
  input  logic [TAG_W-1:0]       wake_tag_i,
  input  logic                   grant_i,
  input  logic [UNIT_W-1:0]      unit_i,
  output ent_state_t             state_o,
  output logic [GRP_W-1:0]       grp_o,
  output logic [TAG_W-1:0]       dest_o,
  output logic [UNIT_W-1:0]      unit_o,
  output logic                   last_o
);
  ent_state_t              state_q;
  logic [TAG_W-1:0]        src_q [NSRC];
  logic [NSRC-1:0]         rdy_q;
  logic [NSRC-1:0]         hit_new, hit_old, rdy_nxt;
  logic [LAT_W-1:0]        lat_q, cnt_q;

  always_comb begin
    for (int k = 0; k < NSRC; k++) begin
      hit_new[k] = wake_v_i && (src_tag_i[k*TAG_W +: TAG_W] == wake_tag_i);
      hit_old[k] = wake_v_i && (src_q[k] == wake_tag_i);
    end
    rdy_nxt = rdy_q | hit_old;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FREE;
      rdy_q   <= '0;
      cnt_q   <= '0;
      lat_q   <= '0;
      grp_o   <= '0;
      dest_o  <= '0;
      unit_o  <= '0;
      for (int k = 0; k < NSRC; k++) src_q[k] <= '0;
    end else if (alloc_i) begin
      for (int k = 0; k < NSRC; k++) src_q[k] <= src_tag_i[k*TAG_W +: TAG_W];
      rdy_q   <= src_rdy_i | hit_new;
      grp_o   <= grp_i;
      dest_o  <= dest_i;
      lat_q   <= lat_i;
      state_q <= (&(src_rdy_i | hit_new)) ? ST_READY : ST_WAIT;
    end else begin
      case (state_q)
        ST_WAIT: begin
          rdy_q <= rdy_nxt;
          if (&rdy_nxt) state_q <= ST_READY;
        end
        ST_READY: if (grant_i) begin
          state_q <= ST_EXEC;
          unit_o  <= unit_i;
          cnt_q   <= (lat_q == '0) ? LAT_W'(1) : lat_q;
        end
        ST_EXEC: begin
          if (cnt_q == LAT_W'(1)) state_q <= ST_FREE;
          else                    cnt_q   <= cnt_q - LAT_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign state_o = state_q;
  assign last_o  = (state_q == ST_EXEC) && (cnt_q == LAT_W'(1));

  assert_grant_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> state_q == ST_READY);
  assert_alloc_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> state_q == ST_FREE);
endmodule

// File: rtl/sched_age_pick.sv
module sched_age_pick #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] alloc_i,
  input  logic [DEPTH-1:0] valid_i,
  input  logic [DEPTH-1:0] elig_i,
  output logic [DEPTH-1:0] grant_o
);
  // older_q[i][j] set: slot i was accepted before slot j
  logic [DEPTH-1:0] older_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        for (int j = 0; j < DEPTH; j++)
          if (alloc_i[j] && i != j) older_q[i][j] <= valid_i[i];
          else if (alloc_i[i])      older_q[i][j] <= 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j != i && elig_i[j] && older_q[j][i]) blocked = 1'b1;
      grant_o[i] = elig_i[i] && !blocked;
    end
  end

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
endmodule

// File: rtl/sched_rr.sv
module sched_rr #(
  parameter int UPG  = 2,
  parameter int LU_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [UPG-1:0]  free_i,
  input  logic            adv_i,
  output logic [LU_W-1:0] pick_o,
  output logic            any_o
);
  logic [LU_W-1:0] ptr_q;

  always_comb begin
    pick_o = ptr_q;
    any_o  = 1'b0;
    for (int off = UPG - 1; off >= 0; off--) begin
      int idx;
      idx = (int'(ptr_q) + off) % UPG;
      if (free_i[idx]) begin
        pick_o = LU_W'(idx);
        any_o  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr_q <= '0;
    else if (adv_i) ptr_q <= (int'(pick_o) == UPG - 1) ? '0 : pick_o + LU_W'(1);
  end

  assert_pick_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> free_i[pick_o]);
endmodule

// File: rtl/sched_issue_queue.sv
module sched_issue_queue
  import sched_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 4,
  parameter int NSRC   = 2,
  parameter int NGRP   = 2,
  parameter int UPG    = 2,
  parameter int LAT_W  = 3,
  localparam int GRP_W  = width_of(NGRP),
  localparam int LU_W   = width_of(UPG),
  localparam int NUNIT  = NGRP * UPG,
  localparam int UNIT_W = width_of(NUNIT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    disp_valid,
  output logic                    disp_ready,
  input  logic [NSRC*TAG_W-1:0]   disp_src_tag,
  input  logic [NSRC-1:0]         disp_src_rdy,
  input  logic [GRP_W-1:0]        disp_grp,
  input  logic [LAT_W-1:0]        disp_lat,
  input  logic [TAG_W-1:0]        disp_dest,
  input  logic                    wake_valid,
  input  logic [TAG_W-1:0]        wake_tag,
  output logic                    iss_valid,
  output logic [TAG_W-1:0]        iss_dest,
  output logic [UNIT_W-1:0]       iss_unit,
  output logic [NUNIT-1:0]        done_vec,
  output logic [NUNIT*TAG_W-1:0]  done_dest
);
  ent_state_t        st     [DEPTH];
  logic [GRP_W-1:0]  grp_e  [DEPTH];
  logic [TAG_W-1:0]  dest_e [DEPTH];
  logic [UNIT_W-1:0] unit_e [DEPTH];
  logic [DEPTH-1:0]  last_e, alloc_vec, valid_vec, elig, grant;
  logic [DEPTH-1:0]  exec_on [NUNIT];
  logic [NUNIT-1:0]  unit_busy;
  logic [UPG-1:0]    gfree  [NGRP];
  logic [LU_W-1:0]   gpick  [NGRP];
  logic [NGRP-1:0]   gany, gadv;
  logic [GRP_W-1:0]  sel_grp;

  // slot allocation: lowest free slot
  always_comb begin
    int fidx;
    fidx = 0;
    disp_ready = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (st[i] == ST_FREE) begin
        fidx = i;
        disp_ready = 1'b1;
      end
    for (int i = 0; i < DEPTH; i++) begin
      alloc_vec[i] = disp_valid && disp_ready && (fidx == i);
      valid_vec[i] = (st[i] != ST_FREE);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    sched_entry #(.TAG_W(TAG_W), .NSRC(NSRC), .GRP_W(GRP_W), .LAT_W(LAT_W),
                  .UNIT_W(UNIT_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .alloc_i(alloc_vec[i]),
      .src_tag_i(disp_src_tag), .src_rdy_i(disp_src_rdy), .grp_i(disp_grp),
      .lat_i(disp_lat), .dest_i(disp_dest),
      .wake_v_i(wake_valid), .wake_tag_i(wake_tag),
      .grant_i(grant[i]), .unit_i(iss_unit),
      .state_o(st[i]), .grp_o(grp_e[i]), .dest_o(dest_e[i]),
      .unit_o(unit_e[i]), .last_o(last_e[i]));
  end

  // unit occupancy and completion
  always_comb begin
    done_dest = '0;
    for (int u = 0; u < NUNIT; u++) begin
      for (int i = 0; i < DEPTH; i++)
        exec_on[u][i] = (st[i] == ST_EXEC) && (unit_e[i] == UNIT_W'(u));
      unit_busy[u] = |(exec_on[u] & ~last_e);
      done_vec[u]  = |(exec_on[u] & last_e);
      for (int i = 0; i < DEPTH; i++)
        if (exec_on[u][i] && last_e[i]) done_dest[u*TAG_W +: TAG_W] = dest_e[i];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar l = 0; l < UPG; l++) begin : g_unit
      assign gfree[g][l] = !unit_busy[g*UPG + l];
    end
    assign gadv[g] = iss_valid && (sel_grp == GRP_W'(g));
    sched_rr #(.UPG(UPG), .LU_W(LU_W)) u_rr (
      .clk(clk), .rst_n(rst_n), .free_i(gfree[g]), .adv_i(gadv[g]),
      .pick_o(gpick[g]), .any_o(gany[g]));
  end

  for (genvar u = 0; u < NUNIT; u++) begin : g_chk
    assert_unit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(exec_on[u]) <= 1);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      elig[i] = (st[i] == ST_READY) && (int'(grp_e[i]) < NGRP) && gany[grp_e[i]];
  end

  sched_age_pick #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc_vec), .valid_i(valid_vec),
    .elig_i(elig), .grant_o(grant));

  always_comb begin
    sel_grp  = '0;
    iss_dest = '0;
    for (int i = 0; i < DEPTH; i++)
      if (grant[i]) begin
        sel_grp  = grp_e[i];
        iss_dest = dest_e[i];
      end
    iss_valid = |grant;
    iss_unit  = UNIT_W'(int'(sel_grp) * UPG + int'(gpick[sel_grp]));
  end
endmodule

// File: tb/sim_sched_issue_queue.sv
module sim_sched_issue_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4, TAG_W = 4, NSRC = 2, NGRP = 2, UPG = 2, LAT_W = 3;
  localparam int NUNIT = NGRP * UPG;
  localparam int GRP_W = 1, UNIT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_ready;
  logic [NSRC*TAG_W-1:0] disp_src_tag = '0;
  logic [NSRC-1:0] disp_src_rdy = '0;
  logic [GRP_W-1:0] disp_grp = '0;
  logic [LAT_W-1:0] disp_lat = '0;
  logic [TAG_W-1:0] disp_dest = '0;
  logic wake_valid = 1'b0;
  logic [TAG_W-1:0] wake_tag = '0;
  logic iss_valid;
  logic [TAG_W-1:0] iss_dest;
  logic [UNIT_W-1:0] iss_unit;
  logic [NUNIT-1:0] done_vec;
  logic [NUNIT*TAG_W-1:0] done_dest;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sched_issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NSRC(NSRC), .NGRP(NGRP),
                      .UPG(UPG), .LAT_W(LAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy), .disp_grp(disp_grp),
    .disp_lat(disp_lat), .disp_dest(disp_dest), .wake_valid(wake_valid),
    .wake_tag(wake_tag), .iss_valid(iss_valid), .iss_dest(iss_dest),
    .iss_unit(iss_unit), .done_vec(done_vec), .done_dest(done_dest));

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model: 0 empty, 1 waiting, 2 ready, 3 executing
  int m_st [DEPTH], m_grp [DEPTH], m_dest [DEPTH], m_lat [DEPTH];
  int m_cnt [DEPTH], m_unit [DEPTH], m_seq [DEPTH];
  int m_src [DEPTH][NSRC];
  bit m_rdy [DEPTH][NSRC];
  int m_rr [NGRP];
  int seq_ctr = 0;
  int e_count, e_sel, e_unit;
  bit e_done [NUNIT];
  int e_ddest [NUNIT];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
    for (int g = 0; g < NGRP; g++) m_rr[g] = 0;
  endtask

  task automatic model_eval();
    bit busy [NUNIT];
    int best;
    e_count = 0;
    for (int u = 0; u < NUNIT; u++) begin
      busy[u] = 0; e_done[u] = 0; e_ddest[u] = 0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (m_st[i] != 0) e_count++;
      if (m_st[i] == 3) begin
        if (m_cnt[i] > 1) busy[m_unit[i]] = 1;
        else begin e_done[m_unit[i]] = 1; e_ddest[m_unit[i]] = m_dest[i]; end
      end
    end
    e_sel = -1; e_unit = 0; best = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_st[i] == 2) begin
        int g, found;
        g = m_grp[i]; found = -1;
        for (int off = 0; off < UPG; off++) begin
          int l;
          l = (m_rr[g] + off) % UPG;
          if (found < 0 && !busy[g*UPG + l]) found = g*UPG + l;
        end
        if (found >= 0 && (e_sel < 0 || m_seq[i] < best)) begin
          e_sel = i; best = m_seq[i]; e_unit = found;
        end
      end
    end
  endtask

  task automatic model_step();
    bit was_free [DEPTH];
    for (int i = 0; i < DEPTH; i++) was_free[i] = (m_st[i] == 0);
    for (int i = 0; i < DEPTH; i++)
      if (m_st[i] == 3) begin
        if (m_cnt[i] == 1) m_st[i] = 0; else m_cnt[i]--;
      end
    if (e_sel >= 0) begin
      m_st[e_sel] = 3;
      m_cnt[e_sel] = (m_lat[e_sel] == 0) ? 1 : m_lat[e_sel];
      m_unit[e_sel] = e_unit;
      m_rr[m_grp[e_sel]] = ((e_unit % UPG) + 1) % UPG;
    end
    for (int i = 0; i < DEPTH; i++)
      if (m_st[i] == 1) begin
        bit all;
        all = 1;
        for (int k = 0; k < NSRC; k++) begin
          if (wake_valid && m_src[i][k] == int'(wake_tag)) m_rdy[i][k] = 1;
          if (!m_rdy[i][k]) all = 0;
        end
        if (all) m_st[i] = 2;
      end
    if (disp_valid && e_count < DEPTH) begin
      int s;
      bit all;
      s = -1;
      for (int i = DEPTH - 1; i >= 0; i--) if (was_free[i]) s = i;
      all = 1;
      for (int k = 0; k < NSRC; k++) begin
        m_src[s][k] = int'(disp_src_tag[k*TAG_W +: TAG_W]);
        m_rdy[s][k] = disp_src_rdy[k] || (wake_valid && m_src[s][k] == int'(wake_tag));
        if (!m_rdy[s][k]) all = 0;
      end
      m_grp[s] = int'(disp_grp); m_dest[s] = int'(disp_dest); m_lat[s] = int'(disp_lat);
      m_seq[s] = seq_ctr++;
      m_st[s] = all ? 2 : 1;
    end
  endtask

  task automatic compare_all();
    chk(disp_ready === (e_count < DEPTH), "R8 disp_ready", int'(disp_ready), int'(e_count < DEPTH));
    chk(iss_valid === (e_sel >= 0), "R2/R3/R6 iss_valid", int'(iss_valid), int'(e_sel >= 0));
    if (e_sel >= 0 && iss_valid === 1'b1) begin
      chk(int'(iss_dest) == m_dest[e_sel], "R4 oldest iss_dest", int'(iss_dest), m_dest[e_sel]);
      chk(int'(iss_unit) == e_unit, "R5 iss_unit", int'(iss_unit), e_unit);
    end
    for (int u = 0; u < NUNIT; u++) begin
      chk(done_vec[u] === e_done[u], "R7/R9 done_vec", int'(done_vec[u]), int'(e_done[u]));
      if (e_done[u] && done_vec[u] === 1'b1)
        chk(int'(done_dest[u*TAG_W +: TAG_W]) == e_ddest[u], "R7 done_dest",
            int'(done_dest[u*TAG_W +: TAG_W]), e_ddest[u]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    model_eval();
    compare_all();
  endtask

  task automatic drive(input bit v, input int s0, input int s1, input bit r0, input bit r1,
                       input int g, input int l, input int d, input bit wv, input int wt);
    disp_valid = v;
    disp_src_tag = {TAG_W'(s1), TAG_W'(s0)};
    disp_src_rdy = {r1, r0};
    disp_grp = GRP_W'(g); disp_lat = LAT_W'(l); disp_dest = TAG_W'(d);
    wake_valid = wv; wake_tag = TAG_W'(wt);
  endtask

  task automatic cyc(input bit v, input int s0, input int s1, input bit r0, input bit r1,
                     input int g, input int l, input int d, input bit wv, input int wt);
    drive(v, s0, s1, r0, r1, g, l, d, wv, wt);
    tick();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic report();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_eval();
    // R1: empty after reset
    chk(disp_ready === 1'b1, "R1 disp_ready after reset", int'(disp_ready), 1);
    chk(iss_valid === 1'b0, "R1 iss_valid after reset", int'(iss_valid), 0);
    chk(done_vec === '0, "R1 done_vec after reset", int'(done_vec), 0);
    compare_all();

    // R2: ready at dispatch -> on issue pins the cycle after the edge, not before
    drive(1, 1, 2, 1, 1, 0, 2, 8, 0, 0);
    chk(iss_valid === 1'b0, "R2 no issue in dispatch cycle", int'(iss_valid), 0);
    tick();
    chk(iss_valid === 1'b1 && iss_dest == 4'd8, "R2 issue next cycle", int'(iss_dest), 8);
    idle(4);

    // R3: waiting source woken by broadcast
    cyc(1, 3, 4, 0, 1, 1, 1, 9, 0, 0);
    chk(iss_valid === 1'b0, "R3 waiting instr not issued", int'(iss_valid), 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 3);
    chk(iss_valid === 1'b1 && iss_dest == 4'd9, "R3 issue after wake", int'(iss_dest), 9);
    idle(4);

    // R8 + R4 + R5: fill with blocked instructions, drop an extra beat, release together
    for (int k = 0; k < DEPTH; k++) cyc(1, 15, 15, 0, 0, 0, 1, k + 1, 0, 0);
    chk(disp_ready === 1'b0, "R8 full queue", int'(disp_ready), 0);
    cyc(1, 0, 0, 1, 1, 0, 1, 14, 0, 0);
    chk(disp_ready === 1'b0, "R8 extra beat dropped", int'(disp_ready), 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 15);
    chk(iss_valid === 1'b1 && iss_dest == 4'd1, "R4 oldest first", int'(iss_dest), 1);
    idle(10);

    // R6: busy group does not block a younger one of the other group
    cyc(1, 0, 0, 1, 1, 0, 6, 2, 0, 0);
    cyc(1, 0, 0, 1, 1, 0, 6, 3, 0, 0);
    cyc(1, 0, 0, 1, 1, 0, 2, 4, 0, 0);
    cyc(1, 0, 0, 1, 1, 1, 0, 5, 0, 0);
    idle(12);

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      drive(r < 60, $urandom_range(0, 7), $urandom_range(0, 7),
            $urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0,
            $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 15),
            $urandom_range(0, 1) == 1, $urandom_range(0, 7));
      tick();
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int w = 0; w < 8; w++) begin
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, w);
      tick();
    end
    idle(30);
    chk(disp_ready === 1'b1 && iss_valid === 1'b0, "R7 drained", int'(disp_ready), 1);
    report();
  end
endmodule